// File: doc/BRIEF.md
# Encoded System Bus Clock Prescaler

This block derives three bus clock enables from a single fast system clock. A main bus stage divides the system clock by a ratio selected through a 4-bit code. Two peripheral bus stages each divide the main bus rate through their own 3-bit code. The two peripheral stages are independent of each other and use the same encoding. Each stage drives a one-cycle enable pulse at its divided rate, timed to the fast clock. Each stage also drives a registered, roughly square divided clock that is meant for observation only.

The codes come from inputs that software writes. A stage samples a new code only when its current division period ends, so a code change never shortens or stretches a period. The main code space is sparse. A clear top bit selects bypass. The set-top-bit codes step through /2, /4, /8 and /16 and then jump to /64. There is no /32 code. Reset puts all three stages in bypass.

Top module: `bus_clk_prescaler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every stage is in bypass. In that state main_en_o and both peripheral enables are 1 (with zero codes applied), and all three observation outputs are 0.
- R2: The main code is 4 bits. Codes with bit 3 clear give division by 1 (main_en_o high every cycle). Codes 4'b1000, 4'b1001, 4'b1010 and 4'b1011 give division by 2, 4, 8 and 16.
- R3: Main codes 4'b1100, 4'b1101, 4'b1110 and 4'b1111 all give division by 64.
- R4: Each peripheral code is 3 bits. Codes with bit 2 clear give one pulse per main enable pulse. Codes 3'b100, 3'b101, 3'b110 and 3'b111 give one pulse every 2, 4, 8 and 16 main enable pulses.
- R5: A peripheral enable is high only in a cycle where main_en_o is also high.
- R6: A stage samples its code only in the cycle that ends its current period, which is the cycle its enable pulses. A code change before that point alters neither the length of the running period nor its pulse.
- R7: For a ratio N of 2 or more, a stage's observation output is high during the first N/2 counts of each period and low during the rest, delayed by one system clock. In bypass it stays low.
- R8: Each peripheral stage's ratio depends only on its own code.
- R9: For a ratio of 2 or more, the enable pulse is exactly one system clock wide and comes in the last cycle of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| main_code_i | input | 4 | Main bus ratio code |
| per_a_code_i | input | 3 | Peripheral bus A ratio code |
| per_b_code_i | input | 3 | Peripheral bus B ratio code |
| main_en_o | output | 1 | Main bus enable pulse |
| per_a_en_o | output | 1 | Peripheral bus A enable pulse |
| per_b_en_o | output | 1 | Peripheral bus B enable pulse |
| main_obs_o | output | 1 | Registered main bus divided clock |
| per_a_obs_o | output | 1 | Registered peripheral A divided clock |
| per_b_obs_o | output | 1 | Registered peripheral B divided clock |

## Verification
Four properties are checked on every cycle:
- Each peripheral enable stays inside the main enable.
- The spacing between consecutive main pulses is always one of the legal ratios.
- The spacing of each peripheral stage, counted in main pulses, is always a legal ratio.
- A rising edge on an observation output always comes two cycles after that stage's enable pulse.

Some behaviour can only be shown by the bench's scenarios, which compare every output on every cycle against an arithmetic model:
- Which ratio each individual code selects.
- That the three /64 codes agree.
- That a code changed mid-period waits for the period boundary.
- The exact duty pattern of the observation clocks.

// File: rtl/prescale_pkg.sv
package prescale_pkg;

   // Default encoding geometry
   localparam int unsigned MAIN_CODE_W_D   = 4;
   localparam int unsigned PER_CODE_W_D    = 3;
   localparam int unsigned LIN_STEPS_D     = 4;   // codes with top bit set that map to /2../2^steps
   localparam int unsigned MAIN_SAT_SHIFT_D = 6;  // shift used by the remaining main codes (/64)

   // Bit width needed to hold a shift amount up to max_shift
   function automatic int unsigned shift_width(input int unsigned max_shift);
      int unsigned w;
      w = 1;
      while ((1 << w) <= max_shift) w++;
      return w;
   endfunction

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ratio_decode.sv
module ratio_decode #(
   parameter int unsigned CODE_W    = 4,
   parameter int unsigned SH_W      = 3,
   parameter int unsigned LIN_STEPS = 4,
   parameter int unsigned SAT_SHIFT = 6
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [SH_W-1:0]   shift_o
);

   localparam int unsigned SEL_W    = CODE_W - 1;
   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   if (CODE_W < 2) begin : g_bad_code_w
      $error("ratio_decode: CODE_W must be at least 2");
   end
   if (LIN_STEPS > SEL_SPAN) begin : g_bad_steps
      $error("ratio_decode: LIN_STEPS exceeds code space");
   end
   if ((1 << SH_W) <= SAT_SHIFT || (1 << SH_W) <= LIN_STEPS) begin : g_bad_sh_w
      $error("ratio_decode: SH_W too narrow for the shifts");
   end

   logic [SEL_W-1:0] sel;
   logic [SH_W-1:0]  lin_shift;

   assign sel       = code_i[SEL_W-1:0];
   assign lin_shift = SH_W'(sel) + SH_W'(1);

   if (LIN_STEPS == SEL_SPAN) begin : g_all_linear
      // every code with the top bit set lands on a power-of-two step
      always_comb begin
         if (!code_i[CODE_W-1]) shift_o = '0;
         else                   shift_o = lin_shift;
      end
   end else begin : g_saturating
      // upper codes collapse onto a single saturated shift
      always_comb begin
         if (!code_i[CODE_W-1])                       shift_o = '0;
         else if (32'(sel) < LIN_STEPS)               shift_o = lin_shift;
         else                                         shift_o = SH_W'(SAT_SHIFT);
      end
   end

endmodule

// File: rtl/div_stage.sv
module div_stage #(
   parameter int unsigned MAX_SHIFT = 6,
   parameter int unsigned SH_W      = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            tick_i,
   input  logic [SH_W-1:0] shift_req_i,
   output logic            en_o,
   output logic            obs_o
);

   localparam int unsigned CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

   if (MAX_SHIFT < 1) begin : g_bad_shift
      $error("div_stage: MAX_SHIFT must be at least 1");
   end

   logic [SH_W-1:0]  sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   span;
   logic [CNT_W-1:0] last_cnt;
   logic [CNT_W-1:0] half_bit;
   logic             at_end;
   logic             obs_d;

   // span = 2^shift, last count of the period = span - 1
   assign span     = (CNT_W+1)'(1) << sh_q;
   assign last_cnt = CNT_W'(span - (CNT_W+1)'(1));
   assign half_bit = last_cnt & ~(last_cnt >> 1);
   assign at_end   = (cnt_q == last_cnt);
   assign en_o     = tick_i & at_end;
   assign obs_d    = (sh_q != '0) && ((cnt_q & half_bit) == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q  <= '0;
         cnt_q <= '0;
         obs_o <= 1'b0;
      end else begin
         obs_o <= obs_d;
         if (tick_i) begin
            if (at_end) begin
               cnt_q <= '0;
               sh_q  <= shift_req_i;   // ratio updates only on a period boundary
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler #(
   parameter int unsigned MAIN_CODE_W    = prescale_pkg::MAIN_CODE_W_D,
   parameter int unsigned PER_CODE_W     = prescale_pkg::PER_CODE_W_D,
   parameter int unsigned LIN_STEPS      = prescale_pkg::LIN_STEPS_D,
   parameter int unsigned MAIN_SAT_SHIFT = prescale_pkg::MAIN_SAT_SHIFT_D
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [MAIN_CODE_W-1:0] main_code_i,
   input  logic [PER_CODE_W-1:0]  per_a_code_i,
   input  logic [PER_CODE_W-1:0]  per_b_code_i,
   output logic                   main_en_o,
   output logic                   per_a_en_o,
   output logic                   per_b_en_o,
   output logic                   main_obs_o,
   output logic                   per_a_obs_o,
   output logic                   per_b_obs_o
);

   localparam int unsigned NUM_PER   = 2;
   localparam int unsigned MAIN_MAX  = prescale_pkg::max_u(MAIN_SAT_SHIFT, LIN_STEPS);
   localparam int unsigned PER_MAX   = LIN_STEPS;
   localparam int unsigned SH_W      = prescale_pkg::shift_width(MAIN_MAX);
   localparam int unsigned PER_SPAN  = 1 << (PER_CODE_W - 1);

   if (PER_CODE_W < 2 || MAIN_CODE_W < 2) begin : g_bad_codes
      $error("bus_clk_prescaler: code widths must be at least 2");
   end
   if (PER_SPAN != LIN_STEPS) begin : g_bad_per_span
      $error("bus_clk_prescaler: peripheral code space must match LIN_STEPS");
   end

   logic [SH_W-1:0] main_shift;

   ratio_decode #(
      .CODE_W   (MAIN_CODE_W),
      .SH_W     (SH_W),
      .LIN_STEPS(LIN_STEPS),
      .SAT_SHIFT(MAIN_SAT_SHIFT)
   ) u_main_dec (
      .code_i (main_code_i),
      .shift_o(main_shift)
   );

   div_stage #(
      .MAX_SHIFT(MAIN_MAX),
      .SH_W     (SH_W)
   ) u_main_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (1'b1),
      .shift_req_i(main_shift),
      .en_o       (main_en_o),
      .obs_o      (main_obs_o)
   );

   logic [PER_CODE_W-1:0] per_code  [NUM_PER];
   logic [SH_W-1:0]       per_shift [NUM_PER];
   logic [NUM_PER-1:0]    per_en;
   logic [NUM_PER-1:0]    per_obs;

   assign per_code[0] = per_a_code_i;
   assign per_code[1] = per_b_code_i;

   for (genvar p = 0; p < NUM_PER; p++) begin : g_per
      ratio_decode #(
         .CODE_W   (PER_CODE_W),
         .SH_W     (SH_W),
         .LIN_STEPS(LIN_STEPS),
         .SAT_SHIFT(PER_MAX)
      ) u_dec (
         .code_i (per_code[p]),
         .shift_o(per_shift[p])
      );

      // peripheral stages advance only on main bus pulses
      div_stage #(
         .MAX_SHIFT(PER_MAX),
         .SH_W     (SH_W)
      ) u_stage (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .tick_i     (main_en_o),
         .shift_req_i(per_shift[p]),
         .en_o       (per_en[p]),
         .obs_o      (per_obs[p])
      );
   end

   assign per_a_en_o  = per_en[0];
   assign per_b_en_o  = per_en[1];
   assign per_a_obs_o = per_obs[0];
   assign per_b_obs_o = per_obs[1];

endmodule

// File: rtl/prescale_checker.sv
module prescale_checker (
   input logic clk_i,
   input logic rst_ni,
   input logic main_en_o,
   input logic per_a_en_o,
   input logic per_b_en_o,
   input logic main_obs_o,
   input logic per_a_obs_o,
   input logic per_b_obs_o
);

   logic [7:0] main_gap_q, a_gap_q, b_gap_q;
   logic [7:0] main_gap, a_gap, b_gap;
   logic       main_seen_q, a_seen_q, b_seen_q;

   function automatic logic legal_main(input logic [7:0] g);
      return (g == 8'd1) || (g == 8'd2) || (g == 8'd4) || (g == 8'd8) ||
             (g == 8'd16) || (g == 8'd64);
   endfunction

   function automatic logic legal_per(input logic [7:0] g);
      return (g == 8'd1) || (g == 8'd2) || (g == 8'd4) || (g == 8'd8) || (g == 8'd16);
   endfunction

   assign main_gap = main_gap_q + 8'd1;
   assign a_gap    = a_gap_q + 8'd1;
   assign b_gap    = b_gap_q + 8'd1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         main_gap_q  <= '0;
         a_gap_q     <= '0;
         b_gap_q     <= '0;
         main_seen_q <= 1'b0;
         a_seen_q    <= 1'b0;
         b_seen_q    <= 1'b0;
      end else begin
         if (main_en_o) begin
            main_gap_q  <= '0;
            main_seen_q <= 1'b1;
         end else if (main_gap_q != 8'hFF) begin
            main_gap_q <= main_gap;
         end
         if (per_a_en_o) begin
            a_gap_q  <= '0;
            a_seen_q <= 1'b1;
         end else if (main_en_o && a_gap_q != 8'hFF) begin
            a_gap_q <= a_gap;
         end
         if (per_b_en_o) begin
            b_gap_q  <= '0;
            b_seen_q <= 1'b1;
         end else if (main_en_o && b_gap_q != 8'hFF) begin
            b_gap_q <= b_gap;
         end
      end
   end

   AST_PER_A_INSIDE_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_a_en_o |-> main_en_o); // R5
   AST_PER_B_INSIDE_MAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per_b_en_o |-> main_en_o); // R5
   AST_MAIN_GAP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (main_en_o && main_seen_q) |-> legal_main(main_gap)); // R2
   AST_PER_A_GAP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_a_en_o && a_seen_q) |-> legal_per(a_gap)); // R4
   AST_PER_B_GAP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_b_en_o && b_seen_q) |-> legal_per(b_gap)); // R8
   AST_MAIN_OBS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(main_obs_o) |-> $past(main_en_o, 2)); // R7
   AST_PER_A_OBS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(per_a_obs_o) |-> $past(per_a_en_o, 2)); // R7
   AST_PER_B_OBS_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(per_b_obs_o) |-> $past(per_b_en_o, 2)); // R7

endmodule

bind bus_clk_prescaler prescale_checker u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .main_en_o  (main_en_o),
   .per_a_en_o (per_a_en_o),
   .per_b_en_o (per_b_en_o),
   .main_obs_o (main_obs_o),
   .per_a_obs_o(per_a_obs_o),
   .per_b_obs_o(per_b_obs_o)
);

// File: tb/tb_bus_clk_prescaler.sv
`timescale 1ns/1ps
module tb_bus_clk_prescaler;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mc = '0;
   logic [2:0] ac = '0;
   logic [2:0] bc = '0;
   logic       main_en, a_en, b_en, main_obs, a_obs, b_obs;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // arithmetic reference: per stage shift, count within period, observation
   int m_sh [3];
   int m_cnt[3];
   int m_obs[3];
   int m_pen[3];

   always #2.5 clk = ~clk;

   bus_clk_prescaler dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .main_code_i (mc),
      .per_a_code_i(ac),
      .per_b_code_i(bc),
      .main_en_o   (main_en),
      .per_a_en_o  (a_en),
      .per_b_en_o  (b_en),
      .main_obs_o  (main_obs),
      .per_a_obs_o (a_obs),
      .per_b_obs_o (b_obs)
   );

   function automatic int dec_main(input logic [3:0] c);
      if (!c[3]) return 0;
      if (c[2:0] < 3'd4) return int'(c[2:0]) + 1;
      return 6;
   endfunction

   function automatic int dec_per(input logic [2:0] c);
      if (!c[2]) return 0;
      return int'(c[1:0]) + 1;
   endfunction

   task automatic chk(input string tag, input string what, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 3; i++) begin
         m_sh[i] = 0; m_cnt[i] = 0; m_obs[i] = 0; m_pen[i] = 0;
      end
   endtask

   function automatic int span(input int i);
      return 1 << m_sh[i];
   endfunction

   // entered and left at a falling edge; drives codes, compares, advances model
   task automatic cycle(input logic [3:0] m, input logic [2:0] a, input logic [2:0] b,
                        input string mtag, input string atag, input string btag);
      int e[3];
      int tick;
      int nsh;
      mc = m; ac = a; bc = b;
      #1;
      e[0] = (m_cnt[0] == span(0) - 1) ? 1 : 0;
      e[1] = (e[0] == 1 && m_cnt[1] == span(1) - 1) ? 1 : 0;
      e[2] = (e[0] == 1 && m_cnt[2] == span(2) - 1) ? 1 : 0;
      chk(mtag, "main_en", int'(main_en), e[0]);
      chk(atag, "per_a_en", int'(a_en), e[1]);
      chk(btag, "per_b_en", int'(b_en), e[2]);
      chk("R7", "main_obs", int'(main_obs), m_obs[0]);
      chk("R7", "per_a_obs", int'(a_obs), m_obs[1]);
      chk("R7", "per_b_obs", int'(b_obs), m_obs[2]);
      chk("R5", "per enable outside main", int'((a_en | b_en) & ~main_en), 0);
      if (m_sh[0] != 0)
         chk("R9", "main_en back-to-back", int'(main_en) & m_pen[0], 0);
      for (int i = 0; i < 3; i++) begin
         m_obs[i] = (m_sh[i] != 0 && m_cnt[i] < span(i) / 2) ? 1 : 0;
         tick = (i == 0) ? 1 : e[0];
         nsh = (i == 0) ? dec_main(m) : ((i == 1) ? dec_per(a) : dec_per(b));
         if (tick == 1) begin
            if (m_cnt[i] == span(i) - 1) begin
               m_cnt[i] = 0;
               m_sh[i] = nsh;
            end else begin
               m_cnt[i] = m_cnt[i] + 1;
            end
         end
         m_pen[i] = e[i];
      end
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      model_reset();
      // R1: reset state while reset is held
      repeat (3) begin
         @(negedge clk);
         #1;
         chk("R1", "main_obs in reset", int'(main_obs), 0);
         chk("R1", "per_a_obs in reset", int'(a_obs), 0);
         chk("R1", "per_b_obs in reset", int'(b_obs), 0);
      end
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      repeat (4) cycle(4'b0000, 3'b000, 3'b000, "R1", "R1", "R1");

      // R2 / R3: every main code, peripherals in bypass
      for (int m = 0; m < 16; m++)
         repeat (140) cycle(4'(m), 3'b000, 3'b000, (m >= 12) ? "R3" : "R2", "R4", "R8");

      // R4 / R8: main at /2, all peripheral code pairs
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            repeat (70) cycle(4'b1000, 3'(a), 3'(b), "R2", "R4", "R8");

      // R6: codes change at arbitrary points within running periods
      for (int k = 0; k < 3000; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (lf[2:0] == 3'd0) mc = lf[6:3];
         if (lf[9:7] == 3'd0) ac = lf[12:10];
         if (lf[15:13] == 3'd1) bc = lf[5:3];
         cycle(mc, ac, bc, "R6", "R6", "R6");
      end

      // R1: reset asserted mid-run clears the stages
      rst_n = 1'b0;
      #1;
      chk("R1", "main_obs after mid reset", int'(main_obs), 0);
      chk("R1", "per_a_obs after mid reset", int'(a_obs), 0);
      chk("R1", "per_b_obs after mid reset", int'(b_obs), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      cycle(4'b1011, 3'b111, 3'b101, "R1", "R1", "R1");
      repeat (600) cycle(4'b1011, 3'b111, 3'b101, "R2", "R4", "R8");

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule